// File: doc/BRIEF.md
# Write-to-Read Interval Scheduler

This block sits inside a DDR SDRAM controller and schedules one write followed by one read. A single request carries both the write address (bank and row) and the read address. The block issues the write, compares the read target with the write and with its own record of which row each bank holds open, and then takes one of three routes to the read. A read to the same bank and the same row goes out as soon as the burst turnaround has passed. A read to the same bank but another row first precharges that bank, then activates the new row, and only then reads. A read to another bank opens that bank when it needs to, without waiting on the write, but the read itself still waits for the burst turnaround.

Every interval is counted in clock cycles by down-counters that stop at zero. The burst length, the write-to-precharge delay, the precharge period and the activate-to-read delay are runtime inputs, and they must stay stable while a sequence is in progress. The output is one command per cycle: its code, its bank and row, and a one-cycle strobe for each command type. When no command is due, the code is a no-operation.

Top module: `sdr_wtr_sched`

## Requirements
- R1: After reset, cmd_o is NOP (0), every strobe is low, req_ready_o is high and every bank is recorded as closed.
- R2: A request is accepted on a clock edge where req_valid_i and req_ready_o are both high. The WRITE (code 3, with the write bank and row) is issued in the next cycle. req_ready_o stays low from that cycle through the READ cycle and returns high in the cycle after the READ. Request fields that change while req_ready_o is low have no effect.
- R3: bl_code_i selects the burst length: 0 gives 2, 1 gives 4, and 2 or 3 gives 8. The turnaround tWRD equals burst length / 2 + 2, which is 3, 4 or 6 cycles.
- R4: When the read uses the write's bank and row, READ (code 2) is issued exactly tWRD cycles after the WRITE, with no other command in between.
- R5: When the read uses the write's bank but a different row, PRECHARGE (code 4, the read bank, row 0) is issued max(t_wpd_i,1) cycles after the WRITE.
- R6: ACTIVE (code 1, with the read bank and row) is issued max(t_rp_i,1) cycles after that bank's PRECHARGE.
- R7: After an ACTIVE, READ is issued at the later of max(t_rcd_i,1) cycles after the ACTIVE and tWRD cycles after the WRITE.
- R8: When the read uses a different bank that already holds the read row open, READ is issued exactly tWRD cycles after the WRITE.
- R9: When the read uses a different bank, the preparation of that bank does not wait on the write. If the bank is closed, ACTIVE follows in the cycle after the WRITE. If it holds another row open, PRECHARGE follows in the cycle after the WRITE.
- R10: The open-row record marks the write's bank as open at the write row, records the row on each ACTIVE, and marks the bank closed on PRECHARGE. Later requests take their route from this record.
- R11: In every cycle without a due command, cmd_o is NOP with bank and row at 0. Exactly the strobe that matches cmd_o is high (wr_stb_o, rd_stb_o, pre_stb_o, act_stb_o), and all strobes are low on NOP.
- R12: Interval counters stop at zero, so a programmed interval of 0 behaves as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write-read pair request valid |
| req_ready_o | output | 1 | Scheduler idle, request can be taken |
| wr_bank_i | input | BANK_W | Write bank |
| wr_row_i | input | ROW_W | Write row |
| rd_bank_i | input | BANK_W | Read bank |
| rd_row_i | input | ROW_W | Read row |
| bl_code_i | input | 2 | Burst length select |
| t_wpd_i | input | TW | Write-to-precharge cycles |
| t_rp_i | input | TW | Precharge-to-activate cycles |
| t_rcd_i | input | TW | Activate-to-read cycles |
| cmd_o | output | 3 | Command code (NOP 0, ACT 1, READ 2, WRITE 3, PRE 4) |
| cmd_bank_o | output | BANK_W | Command bank |
| cmd_row_o | output | ROW_W | Command row |
| wr_stb_o | output | 1 | WRITE issued this cycle |
| rd_stb_o | output | 1 | READ issued this cycle |
| pre_stb_o | output | 1 | PRECHARGE issued this cycle |
| act_stb_o | output | 1 | ACTIVE issued this cycle |

## Verification
The read has two release conditions: the turnaround counted from the write, and the activate-to-read delay counted from an ACTIVE on another bank. These two conditions can expire in the same cycle. The bench provokes this with burst length 8 (tWRD 6) to a closed bank with t_rcd_i of 5, so the ACTIVE at cycle 1 and the turnaround both release the read at cycle 6. The bench requires a single READ at exactly that cycle and no command in any cycle before it. Random pairs also land the two expiries on equal or neighbouring cycles, and each one is judged against the later-of rule from a bench schedule model.

// File: rtl/wtr_sched_pkg.sv
package wtr_sched_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WR, ST_PRE, ST_ACT, ST_RD
  } sched_st_e;

  // write-to-read turnaround: burst/2 + 2
  function automatic logic [3:0] wrd_cycles(input logic [1:0] code);
    case (code)
      2'd0:    wrd_cycles = 4'd3;
      2'd1:    wrd_cycles = 4'd4;
      default: wrd_cycles = 4'd6;
    endcase
  endfunction
endpackage

// File: rtl/sdr_ivl_cnt.sv
module sdr_ivl_cnt #(
  parameter int TW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  // loaded in the anchor cycle with val-1 so zero is reached val cycles later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= (val_i == '0) ? '0 : val_i - 1'b1;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  p_sat_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
  p_dec_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zero_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sdr_open_row_tbl.sv
module sdr_open_row_tbl #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [BANK_W-1:0] set_bank_i,
  input  logic [ROW_W-1:0]  set_row_i,
  input  logic              clr_i,
  input  logic [BANK_W-1:0] clr_bank_i,
  input  logic [BANK_W-1:0] lk_bank_i,
  output logic              lk_vld_o,
  output logic [ROW_W-1:0]  lk_row_o
);
  logic [NUM_BANKS-1:0] vld_q;
  logic [ROW_W-1:0]     row_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[b] <= 1'b0;
        row_q[b] <= '0;
      end else if (set_i && set_bank_i == BANK_W'(b)) begin
        vld_q[b] <= 1'b1;
        row_q[b] <= set_row_i;
      end else if (clr_i && clr_bank_i == BANK_W'(b)) begin
        vld_q[b] <= 1'b0;
      end
    end

    p_set_opens_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i && set_bank_i == BANK_W'(b)) |=> (vld_q[b] && row_q[b] == $past(set_row_i)));
    p_clr_closes_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i && clr_bank_i == BANK_W'(b)) |=> !vld_q[b]);
  end

  assign lk_vld_o = vld_q[lk_bank_i];
  assign lk_row_o = row_q[lk_bank_i];
endmodule

// File: rtl/sdr_wtr_sched.sv
module sdr_wtr_sched
  import wtr_sched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int TW        = 5,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BANK_W-1:0] wr_bank_i,
  input  logic [ROW_W-1:0]  wr_row_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  input  logic [ROW_W-1:0]  rd_row_i,
  input  logic [1:0]        bl_code_i,
  input  logic [TW-1:0]     t_wpd_i,
  input  logic [TW-1:0]     t_rp_i,
  input  logic [TW-1:0]     t_rcd_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic              wr_stb_o,
  output logic              rd_stb_o,
  output logic              pre_stb_o,
  output logic              act_stb_o
);
  sched_st_e         st_q, st_d;
  logic [BANK_W-1:0] wr_bank_q, rd_bank_q;
  logic [ROW_W-1:0]  wr_row_q, rd_row_q;
  logic [1:0]        bl_q;
  logic              same_bank_q;
  sdr_cmd_e          cmd;
  logic              accept;
  logic              wrd_zero, wpd_zero, gap_zero;
  logic              gap_load;
  logic [TW-1:0]     gap_val, wrd_val;
  logic              lk_vld;
  logic [ROW_W-1:0]  lk_row;

  assign accept      = req_valid_i && req_ready_o;
  assign req_ready_o = (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bank_q   <= '0;
      rd_bank_q   <= '0;
      wr_row_q    <= '0;
      rd_row_q    <= '0;
      bl_q        <= '0;
      same_bank_q <= 1'b0;
    end else if (accept) begin
      wr_bank_q   <= wr_bank_i;
      rd_bank_q   <= rd_bank_i;
      wr_row_q    <= wr_row_i;
      rd_row_q    <= rd_row_i;
      bl_q        <= bl_code_i;
      same_bank_q <= (wr_bank_i == rd_bank_i);
    end
  end

  // command due in the current cycle
  always_comb begin
    cmd = CMD_NOP;
    case (st_q)
      ST_WR:  cmd = CMD_WR;
      ST_PRE: if (!same_bank_q || wpd_zero) cmd = CMD_PRE;
      ST_ACT: if (gap_zero) cmd = CMD_ACT;
      ST_RD:  if (wrd_zero && gap_zero) cmd = CMD_RD;
      default: cmd = CMD_NOP;
    endcase
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept) st_d = ST_WR;
      ST_WR: begin
        if (same_bank_q)
          st_d = (rd_row_q == wr_row_q) ? ST_RD : ST_PRE;
        else if (!lk_vld)
          st_d = ST_ACT;
        else
          st_d = (lk_row == rd_row_q) ? ST_RD : ST_PRE;
      end
      ST_PRE: if (cmd == CMD_PRE) st_d = ST_ACT;
      ST_ACT: if (cmd == CMD_ACT) st_d = ST_RD;
      ST_RD:  if (cmd == CMD_RD)  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign wrd_val  = TW'(wrd_cycles(bl_q));
  assign gap_load = (cmd == CMD_WR) || (cmd == CMD_PRE) || (cmd == CMD_ACT);
  always_comb begin
    case (cmd)
      CMD_PRE: gap_val = t_rp_i;
      CMD_ACT: gap_val = t_rcd_i;
      default: gap_val = '0;
    endcase
  end

  sdr_ivl_cnt #(.TW(TW)) u_wrd_cnt (
    .clk_i, .rst_ni, .load_i(cmd == CMD_WR), .val_i(wrd_val), .zero_o(wrd_zero));
  sdr_ivl_cnt #(.TW(TW)) u_wpd_cnt (
    .clk_i, .rst_ni, .load_i(cmd == CMD_WR), .val_i(t_wpd_i), .zero_o(wpd_zero));
  sdr_ivl_cnt #(.TW(TW)) u_gap_cnt (
    .clk_i, .rst_ni, .load_i(gap_load), .val_i(gap_val), .zero_o(gap_zero));

  sdr_open_row_tbl #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_tbl (
    .clk_i, .rst_ni,
    .set_i     ((cmd == CMD_WR) || (cmd == CMD_ACT)),
    .set_bank_i((cmd == CMD_WR) ? wr_bank_q : rd_bank_q),
    .set_row_i ((cmd == CMD_WR) ? wr_row_q : rd_row_q),
    .clr_i     (cmd == CMD_PRE),
    .clr_bank_i(rd_bank_q),
    .lk_bank_i (rd_bank_q),
    .lk_vld_o  (lk_vld),
    .lk_row_o  (lk_row)
  );

  always_comb begin
    cmd_bank_o = '0;
    cmd_row_o  = '0;
    case (cmd)
      CMD_WR: begin cmd_bank_o = wr_bank_q; cmd_row_o = wr_row_q; end
      CMD_PRE: cmd_bank_o = rd_bank_q;
      CMD_ACT, CMD_RD: begin cmd_bank_o = rd_bank_q; cmd_row_o = rd_row_q; end
      default: ;
    endcase
  end

  assign cmd_o     = cmd;
  assign wr_stb_o  = (cmd == CMD_WR);
  assign rd_stb_o  = (cmd == CMD_RD);
  assign pre_stb_o = (cmd == CMD_PRE);
  assign act_stb_o = (cmd == CMD_ACT);

  p_wr_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> wr_stb_o);
  p_ready_after_rd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_o |=> req_ready_o);
  p_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o || pre_stb_o || act_stb_o || rd_stb_o) |-> !req_ready_o);
  p_rd_turnaround_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_o |-> wrd_zero);
  p_pre_wpd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_stb_o && same_bank_q) |-> wpd_zero);
  p_act_rp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_stb_o |-> gap_zero);
  p_rd_rcd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_o |-> gap_zero);
  p_one_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_stb_o, rd_stb_o, pre_stb_o, act_stb_o}));
endmodule

// File: tb/sdr_wtr_sched_test.sv
`timescale 1ns/100ps
module sdr_wtr_sched_test;
  localparam int NB = 4;
  localparam int RW = 12;
  localparam int TW = 5;
  localparam int BW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [BW-1:0] wr_bank = '0, rd_bank = '0;
  logic [RW-1:0] wr_row = '0, rd_row = '0;
  logic [1:0] bl_code = '0;
  logic [TW-1:0] t_wpd = '0, t_rp = '0, t_rcd = '0;
  logic [2:0] cmd;
  logic [BW-1:0] cmd_bank;
  logic [RW-1:0] cmd_row;
  logic wr_stb, rd_stb, pre_stb, act_stb;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit mv [NB];
  int mr [NB];

  always #2.5 clk = ~clk;

  sdr_wtr_sched #(.NUM_BANKS(NB), .ROW_W(RW), .TW(TW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .wr_bank_i(wr_bank), .wr_row_i(wr_row), .rd_bank_i(rd_bank), .rd_row_i(rd_row),
    .bl_code_i(bl_code), .t_wpd_i(t_wpd), .t_rp_i(t_rp), .t_rcd_i(t_rcd),
    .cmd_o(cmd), .cmd_bank_o(cmd_bank), .cmd_row_o(cmd_row),
    .wr_stb_o(wr_stb), .rd_stb_o(rd_stb), .pre_stb_o(pre_stb), .act_stb_o(act_stb));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int wrd_of(input int code);
    return (code == 0) ? 3 : (code == 1) ? 4 : 6;   // R3
  endfunction

  task automatic run_pair(input int wb, input int wr, input int rb, input int rr,
                          input int bl, input int wpd, input int rp, input int rcd,
                          input bit hold, input string tag);
    int pre_k = -1, act_k = -1, rd_k;
    int wrd = wrd_of(bl);
    if (rb == wb) begin
      if (rr == wr) rd_k = wrd;                           // R4
      else begin
        pre_k = max2(wpd, 1);                             // R5
        act_k = pre_k + max2(rp, 1);                      // R6
        rd_k  = max2(act_k + max2(rcd, 1), wrd);          // R7
      end
    end else if (mv[rb] && mr[rb] == rr) begin
      rd_k = wrd;                                         // R8
    end else if (mv[rb]) begin
      pre_k = 1;                                          // R9
      act_k = 1 + max2(rp, 1);
      rd_k  = max2(act_k + max2(rcd, 1), wrd);
    end else begin
      act_k = 1;                                          // R9
      rd_k  = max2(1 + max2(rcd, 1), wrd);
    end

    @(negedge clk);
    t_wpd = TW'(wpd); t_rp = TW'(rp); t_rcd = TW'(rcd);
    chk(req_ready === 1'b1, {"R2 ready idle ", tag}, req_ready, 1);
    req_valid = 1'b1;
    wr_bank = BW'(wb); wr_row = RW'(wr); rd_bank = BW'(rb); rd_row = RW'(rr);
    bl_code = 2'(bl);
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    for (int k = 0; k <= rd_k; k++) begin
      int ec, eb, er;
      if (k == 0)          begin ec = 3; eb = wb; er = wr; end
      else if (k == pre_k) begin ec = 4; eb = rb; er = 0;  end
      else if (k == act_k) begin ec = 1; eb = rb; er = rr; end
      else if (k == rd_k)  begin ec = 2; eb = rb; er = rr; end
      else                 begin ec = 0; eb = 0;  er = 0;  end
      chk(int'(cmd) == ec, $sformatf("R4/R5/R6/R7 cmd k=%0d %s", k, tag), cmd, ec);
      chk(int'(cmd_bank) == eb && int'(cmd_row) == er,
          $sformatf("R11 addr k=%0d %s", k, tag), {cmd_bank, cmd_row}, (eb << RW) | er);
      chk({wr_stb, rd_stb, pre_stb, act_stb} ==
          {ec == 3, ec == 2, ec == 4, ec == 1},
          $sformatf("R11 strobes k=%0d %s", k, tag),
          {wr_stb, rd_stb, pre_stb, act_stb}, {ec == 3, ec == 2, ec == 4, ec == 1});
      chk(req_ready === 1'b0, $sformatf("R2 busy k=%0d %s", k, tag), req_ready, 0);
      if (hold) begin
        wr_bank = BW'($urandom); rd_bank = BW'($urandom);
        wr_row = RW'($urandom); rd_row = RW'($urandom); bl_code = 2'($urandom);
        if (k == rd_k) req_valid = 1'b0;
      end
      @(negedge clk);
    end
    chk(req_ready === 1'b1 && int'(cmd) == 0, {"R2 back to idle ", tag}, cmd, 0);
    mv[wb] = 1'b1; mr[wb] = wr;                           // R10
    if (pre_k >= 0) mv[rb] = 1'b0;
    if (act_k >= 0) begin mv[rb] = 1'b1; mr[rb] = rr; end
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0000_5eed));
    for (int b = 0; b < NB; b++) begin mv[b] = 1'b0; mr[b] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(int'(cmd) == 0, "R1 cmd NOP", cmd, 0);
    chk({wr_stb, rd_stb, pre_stb, act_stb} == 4'b0, "R1 strobes", {wr_stb, rd_stb, pre_stb, act_stb}, 0);
    chk(req_ready === 1'b1, "R1 ready", req_ready, 1);
    // R1/R10: all banks closed -> other-bank read takes the activate route
    run_pair(0, 5, 1, 7, 1, 3, 2, 2, 1'b0, "R1 closed bank");
    // R4/R3 same row, each burst code
    run_pair(1, 7, 1, 7, 1, 2, 2, 2, 1'b0, "R4 bl4");
    run_pair(1, 7, 1, 7, 0, 2, 2, 2, 1'b0, "R3 bl2");
    run_pair(1, 7, 1, 7, 2, 2, 2, 2, 1'b0, "R3 bl8");
    run_pair(1, 7, 1, 7, 3, 2, 2, 2, 1'b0, "R3 code3");
    // R5/R6/R7 same bank other row, normal and zero timings (R12)
    run_pair(1, 7, 1, 9, 1, 4, 3, 3, 1'b0, "R5 R6 R7");
    run_pair(2, 1, 2, 3, 2, 0, 0, 0, 1'b0, "R12 zero timing");
    // R8 other bank open at same row (bank 1 holds row 9)
    run_pair(0, 2, 1, 9, 0, 1, 1, 1, 1'b0, "R8 open hit");
    // R9 other bank open at another row
    run_pair(0, 2, 1, 4, 1, 1, 2, 3, 1'b0, "R9 open miss");
    // turnaround and activate-to-read expire together
    run_pair(0, 2, 3, 6, 2, 1, 1, 5, 1'b0, "R7 coincide");
    // R2 fields changing while busy are ignored
    run_pair(3, 6, 3, 8, 1, 5, 2, 2, 1'b1, "R2 hold");
    for (int i = 0; i < 60; i++) begin
      run_pair(int'($urandom_range(NB - 1)), int'($urandom_range(3)),
               int'($urandom_range(NB - 1)), int'($urandom_range(3)),
               int'($urandom_range(3)), int'($urandom_range(7)),
               int'($urandom_range(6)), int'($urandom_range(6)),
               bit'($urandom_range(1)), "random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule